// File: doc/BRIEF.md
# Two-Source Byte Shuffle Unit

This block forms a 128-bit result vector by choosing each of its 16 bytes from a 32-byte pool made of two source vectors placed side by side, the first source (`va`) followed by the second (`vb`). A third 128-bit operand, the control vector, holds one selector byte per result byte. The unit knows nothing about element types: every result byte is routed on its own, so one datapath serves byte, halfword and word rearrangements alike.

Typical use is inside a vector execution pipeline. Fixed control patterns pull the even or odd 32-bit words of two interleaved vectors apart (real and imaginary parts, for instance), and the matching merge patterns weave two word streams back into interleaved form. A parameter selects between a purely combinational result and a single output register with a valid flag that travels alongside the data.

Top module: `vperm_unit`

## Requirements
- R1: Pool bytes are numbered 0 to 31. Byte k for k below 16 is byte k of `va`, and byte k for k from 16 to 31 is byte k-16 of `vb`. A selector value k puts pool byte k into the result.
- R2: Byte numbering is big-endian. Byte i of any 128-bit port occupies bits [127-8i : 120-8i]. The selector in byte i of `ctrl` decides byte i of `vd`.
- R3: Only bits [4:0] of each selector byte are used. Bits [7:5] have no effect on the result.
- R4: Every result byte is chosen independently of the others. Selectors may repeat (for example, one pool byte broadcast to all lanes) and may appear in any order.
- R5: Selector bytes 0-3, 8-11, 16-19, 24-27 in that lane order give {A.w0, A.w2, B.w0, B.w2}, where w0 is the most significant 32-bit word.
- R6: Selector bytes 4-7, 12-15, 20-23, 28-31 give {A.w1, A.w3, B.w1, B.w3}.
- R7: Selector bytes 0-3, 16-19, 4-7, 20-23 give {A.w0, B.w0, A.w1, B.w1}. Selector bytes 8-11, 24-27, 12-15, 28-31 give {A.w2, B.w2, A.w3, B.w3}.
- R8: With the output register enabled (REG_OUT=1), the result for operands sampled with `in_valid` high appears on `vd` after exactly one rising clock edge. `out_valid` is high in that cycle and low after a cycle in which `in_valid` was low.
- R9: With REG_OUT=1, a cycle with `in_valid` low leaves `vd` unchanged, whatever the operands are.
- R10: While `rst_n` is low, `out_valid` is 0 and `vd` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| va | input | 128 | First source; pool bytes 0-15 |
| vb | input | 128 | Second source; pool bytes 16-31 |
| ctrl | input | 128 | One selector byte per result byte |
| out_valid | output | 1 | `vd` holds a fresh result |
| vd | output | 128 | Shuffled result |

## Verification
Identity selectors for each source show that the two halves of the pool are not swapped. A reversed selector shows that numbering runs from the most significant byte and that lanes are not mirrored. A broadcast selector shows that a lane does not depend on its neighbours. The four word patterns are checked against expected values built directly from 32-bit words, so a byte-order slip inside a word is caught. Selectors with their upper bits set are compared against the same selectors masked, which exposes any use of bits [7:5]. Several hundred seeded random operand and selector triples, with the full 8-bit selector range, cover the remaining crossbar paths. Idle cycles with changing operands show that the register holds its value and that the valid flag drops.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

   localparam int unsigned DEF_LANES = 16;
   localparam int unsigned DEF_ELEM_BITS = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vperm_lane_sel.sv
module vperm_lane_sel #(
   parameter int unsigned NUM_BYTES = 16,
   parameter int unsigned ELEM_BITS = 8
) (
   input  logic [2*NUM_BYTES*ELEM_BITS-1:0] pool,
   input  logic [ELEM_BITS-1:0]             sel_code,
   output logic [ELEM_BITS-1:0]             lane_out
);
   localparam int unsigned POOL_N = 2 * NUM_BYTES;
   localparam int unsigned IDX_W  = $clog2(POOL_N);

   logic [IDX_W-1:0]     idx;
   logic [ELEM_BITS-1:0] pool_b [POOL_N];

   // truncation drops the upper selector bits (R3)
   assign idx = IDX_W'(sel_code);

   always_comb begin
      for (int k = 0; k < POOL_N; k++) begin
         pool_b[k] = pool[(POOL_N-1-k)*ELEM_BITS +: ELEM_BITS];
      end
   end

   assign lane_out = pool_b[idx];

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar #(
   parameter int unsigned NUM_BYTES = 16,
   parameter int unsigned ELEM_BITS = 8
) (
   input  logic [NUM_BYTES*ELEM_BITS-1:0] src_a,
   input  logic [NUM_BYTES*ELEM_BITS-1:0] src_b,
   input  logic [NUM_BYTES*ELEM_BITS-1:0] sel_vec,
   output logic [NUM_BYTES*ELEM_BITS-1:0] res
);
   localparam int unsigned VEC_W = NUM_BYTES * ELEM_BITS;

   logic [2*VEC_W-1:0] pool;
   assign pool = {src_a, src_b};

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
      vperm_lane_sel #(
         .NUM_BYTES(NUM_BYTES),
         .ELEM_BITS(ELEM_BITS)
      ) lane_i (
         .pool    (pool),
         .sel_code(sel_vec[(NUM_BYTES-1-i)*ELEM_BITS +: ELEM_BITS]),
         .lane_out(res[(NUM_BYTES-1-i)*ELEM_BITS +: ELEM_BITS])
      );
   end

endmodule

// File: rtl/vperm_out_stage.sv
module vperm_out_stage #(
   parameter int unsigned WIDTH   = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] d_in,
   output logic             out_valid,
   output logic [WIDTH-1:0] d_out
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            d_out     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) d_out <= d_in;
         end
      end

      p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_data_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (d_out == $past(d_in)));
      p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(d_out));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign d_out     = d_in;
   end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
   import vperm_pkg::*;
#(
   parameter int unsigned NUM_BYTES = DEF_LANES,
   parameter int unsigned ELEM_BITS = DEF_ELEM_BITS,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [NUM_BYTES*ELEM_BITS-1:0] va,
   input  logic [NUM_BYTES*ELEM_BITS-1:0] vb,
   input  logic [NUM_BYTES*ELEM_BITS-1:0] ctrl,
   output logic                         out_valid,
   output logic [NUM_BYTES*ELEM_BITS-1:0] vd
);
   localparam int unsigned VEC_W = NUM_BYTES * ELEM_BITS;
   localparam int unsigned IDX_W = $clog2(2 * NUM_BYTES);

   if (!is_pow2(NUM_BYTES)) begin : g_chk_pow2
      $error("vperm_unit: NUM_BYTES must be a power of two");
   end
   if (NUM_BYTES < 2) begin : g_chk_min
      $error("vperm_unit: NUM_BYTES must be at least 2");
   end
   if (ELEM_BITS < IDX_W) begin : g_chk_sel
      $error("vperm_unit: selector byte too narrow to index the pool");
   end

   logic [VEC_W-1:0] shuffled;

   vperm_xbar #(
      .NUM_BYTES(NUM_BYTES),
      .ELEM_BITS(ELEM_BITS)
   ) xbar_i (
      .src_a  (va),
      .src_b  (vb),
      .sel_vec(ctrl),
      .res    (shuffled)
   );

   vperm_out_stage #(
      .WIDTH  (VEC_W),
      .REG_OUT(REG_OUT)
   ) ostage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .d_in     (shuffled),
      .out_valid(out_valid),
      .d_out    (vd)
   );

   function automatic logic [VEC_W-1:0] ramp_sel(input int unsigned base);
      logic [VEC_W-1:0] r;
      for (int i = 0; i < NUM_BYTES; i++) begin
         r[(NUM_BYTES-1-i)*ELEM_BITS +: ELEM_BITS] = ELEM_BITS'(base + i);
      end
      return r;
   endfunction

   localparam logic [VEC_W-1:0] SEL_ID_A = ramp_sel(0);
   localparam logic [VEC_W-1:0] SEL_ID_B = ramp_sel(NUM_BYTES);

   if (REG_OUT) begin : g_sva
      p_ident_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ctrl == SEL_ID_A) |=> (vd == $past(va)));
      p_ident_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ctrl == SEL_ID_B) |=> (vd == $past(vb)));
      p_reset_idle_r10: assert property (@(posedge clk)
         !rst_n |-> (!out_valid && vd == '0));
   end

endmodule

// File: tb/vperm_unit_tb.sv
module vperm_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] va = '0, vb = '0, ctrl = '0;
   logic         out_valid;
   logic [127:0] vd;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vperm_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .va(va), .vb(vb), .ctrl(ctrl),
      .out_valid(out_valid), .vd(vd)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input logic [127:0] c);
      logic [255:0] cat;
      logic [127:0] r;
      cat = {a, b};
      for (int i = 0; i < 16; i++) begin
         int idx;
         idx = int'(c[127-8*i -: 8]) % 32;
         r[127-8*i -: 8] = cat[255-8*idx -: 8];
      end
      return r;
   endfunction

   function automatic logic [127:0] sel_words(input int w0, input int w1,
                                              input int w2, input int w3);
      logic [127:0] r;
      int st [4];
      st[0] = w0; st[1] = w1; st[2] = w2; st[3] = w3;
      for (int i = 0; i < 16; i++) r[127-8*i -: 8] = 8'(st[i/4] + i%4);
      return r;
   endfunction

   function automatic logic [31:0] wd(input logic [127:0] v, input int k);
      return v[127-32*k -: 32];
   endfunction

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
      @(negedge clk);
      va = a; vb = b; ctrl = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] a, b, c, hold;
      void'($urandom(32'h5eed_0713));
      repeat (3) @(negedge clk);
      check("R10 vd in reset", vd, '0);
      check("R10 out_valid in reset", {127'd0, out_valid}, '0);
      rst_n = 1'b1;

      a = 128'h00112233_44556677_8899aabb_ccddeeff;
      b = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;

      apply(a, b, sel_words(0, 4, 8, 12));
      check("R1 identity A", vd, a);
      check("R8 out_valid after one edge", {127'd0, out_valid}, 128'd1);
      apply(a, b, sel_words(16, 20, 24, 28));
      check("R1 identity B", vd, b);

      c = '0;
      for (int i = 0; i < 16; i++) c[127-8*i -: 8] = 8'(15 - i);
      apply(a, b, c);
      check("R2 reversal", vd, 128'hffeeddcc_bbaa9988_77665544_33221100);

      c = {16{8'd7}};
      apply(a, b, c);
      check("R4 broadcast", vd, {16{8'h77}});

      c = sel_words(28, 1, 17, 6);
      c = c | {16{8'he0}};
      apply(a, b, c);
      check("R3 upper bits ignored", vd, model(a, b, sel_words(28, 1, 17, 6)));

      apply(a, b, sel_words(0, 8, 16, 24));
      check("R5 even words", vd, {wd(a,0), wd(a,2), wd(b,0), wd(b,2)});
      apply(a, b, sel_words(4, 12, 20, 28));
      check("R6 odd words", vd, {wd(a,1), wd(a,3), wd(b,1), wd(b,3)});
      apply(a, b, sel_words(0, 16, 4, 20));
      check("R7 merge high", vd, {wd(a,0), wd(b,0), wd(a,1), wd(b,1)});
      apply(a, b, sel_words(8, 24, 12, 28));
      check("R7 merge low", vd, {wd(a,2), wd(b,2), wd(a,3), wd(b,3)});

      // R9 hold and R8 valid drop during idle cycles with changing operands
      hold = vd;
      @(negedge clk);
      va = ~a; vb = ~b; ctrl = sel_words(3, 9, 18, 27);
      @(negedge clk);
      check("R8 out_valid low when idle", {127'd0, out_valid}, '0);
      check("R9 hold while idle", vd, hold);

      for (int n = 0; n < 400; n++) begin
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         c = {$urandom, $urandom, $urandom, $urandom};
         apply(a, b, c);
         check("R1 R4 random", vd, model(a, b, c));
         if (n % 50 == 0) begin
            hold = vd;
            @(negedge clk);
            va = b; vb = a;
            check("R9 random hold", vd, hold);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule